// File: doc/BRIEF.md
# Dual-Master Bus Arbiter with Lock

This block decides which of two bus masters may drive a shared external bus. Each master presents a request and a lock input and receives a grant. A common active-low busy line, driven by whichever master is running a bus cycle, tells the arbiter when a cycle is in flight. Grants are registered, exactly one of them is high at any time, and a grant only moves at a clock edge where busy is sampled inactive. When nothing is requested, the last master granted keeps the bus as implicit owner. This holds even if it never drives a cycle.

A parameter picks the policy. In alternating mode (`PRIO_MODE = 0`), any request from the non-owner takes the bus at the next idle edge. This happens even if the owner has not yet run a single cycle. Such a zero-length tenure is deliberate: the arbiter never waits for a newly granted master to use the bus, so a master that dropped its request cannot stall arbitration. In priority mode (`PRIO_MODE = 1`), master 1 wins whenever it asks. In that mode a lock input counts as a request. Master 2 keeps the bus past a master 1 request only while it holds its lock. In both modes the current owner keeps the bus for as long as its lock is high. No early lock-release indication is used.

The controller has four states:
- PARK1 and PARK2 mean that master 1 or master 2 owns the bus and the bus is idle.
- XFER1 and XFER2 mean that the owner has a cycle in flight.

The transitions are:
- PARKn goes to XFERn when busy is sampled low.
- XFERn stays in XFERn while busy is low.
- From PARKn or XFERn, with busy sampled high, the controller goes to PARK1 or PARK2 as chosen by the policy. This is the handover point, and the new owner's grant appears right after that edge.

Top module: `dual_bus_arbiter`

## Requirements
- R1: After reset, grant_m1 is 1 and grant_m2 is 0.
- R2: In every clock cycle, at most one grant is high; grant bits are grant_m1 (master 1) and grant_m2 (master 2).
- R3: At a clock edge where busy_n is sampled 0, neither grant changes.
- R4: With busy_n high and no request or lock from either master, the current owner keeps its grant indefinitely (implicit ownership).
- R5: Alternating mode: with busy_n high, an unlocked owner loses the grant at the next edge when the other master requests. This holds whether or not the owner ran any cycle, and also when both masters request, in which case the non-owner wins.
- R6: In either mode, an owner whose lock input is high at an edge still owns the bus after that edge.
- R7: Priority mode: with busy_n high, master 1 is granted at the next edge if req_m1 or lock_m1 is high. The exception is when master 2 owns the bus with lock_m2 high.
- R8: Priority mode: master 2 takes the bus only when master 1 has neither request nor lock high. In that case, lock_m2 alone is enough.
- R9: When busy_n returns high after a cycle, a pending handover takes effect at the first edge that samples busy_n high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_m1 | input | 1 | Bus request from master 1 |
| req_m2 | input | 1 | Bus request from master 2 |
| lock_m1 | input | 1 | Master 1 is inside a locked sequence |
| lock_m2 | input | 1 | Master 2 is inside a locked sequence |
| busy_n | input | 1 | Shared bus-busy line, active low |
| grant_m1 | output | 1 | Bus granted to master 1 |
| grant_m2 | output | 1 | Bus granted to master 2 |

## Verification
The bench hands the bus back and forth while the owner runs no cycle at all. A design that waited for the owner to use the bus would leave the grant stuck on an idle master.

It raises a competing request while busy is low. A design that rearbitrates mid-cycle would switch grants under a running transfer. It also checks that the switch lands on the very first idle edge, not one cycle later.

Locked sequences are driven in both modes. A design that yields a locked owner to a priority request, or ignores a lone lock from master 2 in priority mode, shows the wrong grant after that edge.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int unsigned NUM_MASTERS = 2;

    typedef enum logic [1:0] {
        ST_PARK1 = 2'd0,
        ST_PARK2 = 2'd1,
        ST_XFER1 = 2'd2,
        ST_XFER2 = 2'd3
    } arb_state_e;

    typedef enum logic {
        OWN_M1 = 1'b0,
        OWN_M2 = 1'b1
    } owner_e;
endpackage

// File: rtl/arb_req_cond.sv
module arb_req_cond
    import arb_pkg::*;
#(
    parameter bit PRIO_MODE = 1'b0
) (
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] lock_i,
    output logic [NUM_MASTERS-1:0] eff_req_o
);
    generate
        if (PRIO_MODE) begin : g_prio
            // a held lock is a stronger form of request
            assign eff_req_o = req_i | lock_i;
        end else begin : g_fair
            logic [NUM_MASTERS-1:0] lock_unused;
            assign lock_unused = lock_i;
            assign eff_req_o   = req_i;
        end
    endgenerate
endmodule

// File: rtl/arb_policy.sv
module arb_policy
    import arb_pkg::*;
#(
    parameter bit PRIO_MODE = 1'b0
) (
    input  owner_e                 owner_i,
    input  logic [NUM_MASTERS-1:0] eff_req_i,
    input  logic [NUM_MASTERS-1:0] lock_i,
    output owner_e                 pick_o
);
    owner_e other;
    logic   owner_locked;

    assign other        = (owner_i == OWN_M1) ? OWN_M2 : OWN_M1;
    assign owner_locked = lock_i[int'(owner_i)];

    generate
        if (PRIO_MODE) begin : g_prio
            always_comb begin
                if (owner_locked)        pick_o = owner_i;
                else if (eff_req_i[0])   pick_o = OWN_M1;
                else if (eff_req_i[1])   pick_o = OWN_M2;
                else                     pick_o = owner_i;
            end
        end else begin : g_fair
            always_comb begin
                if (owner_locked)                   pick_o = owner_i;
                else if (eff_req_i[int'(other)])    pick_o = other;
                else                                pick_o = owner_i;
            end
        end
    endgenerate
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   busy_n,
    input  owner_e                 pick_i,
    output owner_e                 owner_o,
    output logic [NUM_MASTERS-1:0] grant_o
);
    arb_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PARK1, ST_XFER1: begin
                if (!busy_n)                 state_d = ST_XFER1;
                else if (pick_i == OWN_M2)   state_d = ST_PARK2;
                else                         state_d = ST_PARK1;
            end
            ST_PARK2, ST_XFER2: begin
                if (!busy_n)                 state_d = ST_XFER2;
                else if (pick_i == OWN_M1)   state_d = ST_PARK1;
                else                         state_d = ST_PARK2;
            end
            default: state_d = ST_PARK1;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PARK1;
        else        state_q <= state_d;
    end

    assign owner_o = (state_q == ST_PARK2 || state_q == ST_XFER2) ? OWN_M2 : OWN_M1;

    // registered grant outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o <= 2'b01;
        end else begin
            unique case (state_d)
                ST_PARK1, ST_XFER1: grant_o <= 2'b01;
                ST_PARK2, ST_XFER2: grant_o <= 2'b10;
                default:            grant_o <= 2'b01;
            endcase
        end
    end

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R2
    AST_HOLD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |=> $stable(grant_o)); // R3
endmodule

// File: rtl/dual_bus_arbiter.sv
module dual_bus_arbiter
    import arb_pkg::*;
#(
    parameter bit PRIO_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_m1,
    input  logic req_m2,
    input  logic lock_m1,
    input  logic lock_m2,
    input  logic busy_n,
    output logic grant_m1,
    output logic grant_m2
);
    logic [NUM_MASTERS-1:0] req_v, lock_v, eff_req, grant_v;
    owner_e                 owner, pick;

    assign req_v  = {req_m2, req_m1};
    assign lock_v = {lock_m2, lock_m1};

    arb_req_cond #(.PRIO_MODE(PRIO_MODE)) u_req_cond (
        .req_i     (req_v),
        .lock_i    (lock_v),
        .eff_req_o (eff_req)
    );

    arb_policy #(.PRIO_MODE(PRIO_MODE)) u_policy (
        .owner_i   (owner),
        .eff_req_i (eff_req),
        .lock_i    (lock_v),
        .pick_o    (pick)
    );

    arb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_n  (busy_n),
        .pick_i  (pick),
        .owner_o (owner),
        .grant_o (grant_v)
    );

    assign grant_m1 = grant_v[0];
    assign grant_m2 = grant_v[1];

    AST_LOCK1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_m1 && lock_m1) |=> grant_m1); // R6
    AST_LOCK2_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_m2 && lock_m2) |=> grant_m2); // R6

    generate
        if (PRIO_MODE) begin : g_prio_chk
            AST_M1_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_n && (req_m1 || lock_m1) && !(grant_m2 && lock_m2)) |=> grant_m1); // R7
            AST_M2_ONLY_IDLE_M1: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_m1 && busy_n && (req_m1 || lock_m1)) |=> grant_m1); // R8
        end else begin : g_fair_chk
            AST_NULL_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_n && grant_m1 && !lock_m1 && req_m2) |=> grant_m2); // R5
            AST_NULL_TENURE2: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_n && grant_m2 && !lock_m2 && req_m1) |=> grant_m1); // R5
        end
    endgenerate
endmodule

// File: tb/dual_bus_arbiter_bench.sv
module dual_bus_arbiter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_m1 = 1'b0, req_m2 = 1'b0, lock_m1 = 1'b0, lock_m2 = 1'b0;
    logic busy_n = 1'b1;
    logic f_g1, f_g2, p_g1, p_g2;
    int   n_tests = 0;
    int   n_fail  = 0;

    always #4 clk = ~clk; // 125 MHz

    dual_bus_arbiter #(.PRIO_MODE(1'b0)) u_dual_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_m1(req_m1), .req_m2(req_m2),
        .lock_m1(lock_m1), .lock_m2(lock_m2), .busy_n(busy_n),
        .grant_m1(f_g1), .grant_m2(f_g2)
    );

    dual_bus_arbiter #(.PRIO_MODE(1'b1)) u_dual_bus_arbiter_prio (
        .clk(clk), .rst_n(rst_n), .req_m1(req_m1), .req_m2(req_m2),
        .lock_m1(lock_m1), .lock_m2(lock_m2), .busy_n(busy_n),
        .grant_m1(p_g1), .grant_m2(p_g2)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: grants {m2,m1} = %b, expected %b", tag, act, exp);
        end
    endtask

    // one clock edge, then settle away from the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic r1, input logic r2, input logic l1, input logic l2, input logic b);
        req_m1 = r1; req_m2 = r2; lock_m1 = l1; lock_m2 = l2; busy_n = b;
    endtask

    task automatic do_reset();
        drive(0, 0, 0, 0, 1);
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 fair reset owner", {f_g2, f_g1}, 2'b01);
        check("R1 prio reset owner", {p_g2, p_g1}, 2'b01);
        check("R2 single grant", {1'b0, f_g1 & f_g2}, 2'b00);
    endtask

    task automatic t_implicit();
        do_reset();
        drive(0, 0, 0, 0, 1);
        step(); step(); step();
        check("R4 implicit owner m1 fair", {f_g2, f_g1}, 2'b01);
        check("R4 implicit owner m1 prio", {p_g2, p_g1}, 2'b01);
    endtask

    task automatic t_fair_null_tenure();
        do_reset();
        drive(0, 1, 0, 0, 1);
        step();
        check("R5 m2 request takes idle bus", {f_g2, f_g1}, 2'b10);
        drive(1, 0, 0, 0, 1);
        step();
        check("R5 null tenure back to m1", {f_g2, f_g1}, 2'b01);
        drive(1, 1, 0, 0, 1);
        step();
        check("R5 both request -> non-owner m2", {f_g2, f_g1}, 2'b10);
        step();
        check("R5 both request -> non-owner m1", {f_g2, f_g1}, 2'b01);
        drive(0, 0, 0, 0, 1);
        step(); step();
        check("R4 m1 keeps bus after requests stop", {f_g2, f_g1}, 2'b01);
    endtask

    task automatic t_busy_hold();
        do_reset();
        drive(0, 1, 0, 0, 0);
        step();
        check("R3 no switch while busy (1)", {f_g2, f_g1}, 2'b01);
        step();
        check("R3 no switch while busy (2)", {f_g2, f_g1}, 2'b01);
        check("R3 prio no switch while busy", {p_g2, p_g1}, 2'b01);
        drive(0, 1, 0, 0, 1);
        step();
        check("R9 handover on first idle edge fair", {f_g2, f_g1}, 2'b10);
        check("R9 handover on first idle edge prio", {p_g2, p_g1}, 2'b10);
    endtask

    task automatic t_lock_hold();
        do_reset();
        drive(0, 1, 1, 0, 1);
        step(); step();
        check("R6 fair locked m1 keeps bus", {f_g2, f_g1}, 2'b01);
        drive(0, 1, 0, 0, 1);
        step();
        check("R6 fair release after lock drops", {f_g2, f_g1}, 2'b10);
        drive(1, 0, 0, 1, 1);
        step(); step();
        check("R6 fair locked m2 keeps bus", {f_g2, f_g1}, 2'b10);
    endtask

    task automatic t_prio();
        do_reset();
        drive(0, 1, 0, 0, 1);
        step();
        check("R8 m2 granted when m1 silent", {p_g2, p_g1}, 2'b10);
        drive(1, 1, 0, 0, 1);
        step();
        check("R7 m1 request preempts m2", {p_g2, p_g1}, 2'b01);
        step();
        check("R8 m2 held off while m1 requests", {p_g2, p_g1}, 2'b01);
        drive(0, 1, 0, 0, 1);
        step();
        check("R8 m2 granted after m1 drops", {p_g2, p_g1}, 2'b10);
        drive(1, 0, 0, 1, 1);
        step(); step();
        check("R7 locked m2 outranks m1", {p_g2, p_g1}, 2'b10);
        drive(1, 0, 0, 0, 1);
        step();
        check("R7 m1 wins once m2 lock drops", {p_g2, p_g1}, 2'b01);
        drive(0, 0, 0, 1, 1);
        step();
        check("R8 lone lock_m2 acts as request", {p_g2, p_g1}, 2'b10);
        drive(0, 1, 1, 0, 1);
        step();
        check("R7 lock_m1 alone acts as request", {p_g2, p_g1}, 2'b01);
    endtask

    initial begin
        t_reset();
        t_implicit();
        t_fair_null_tenure();
        t_busy_hold();
        t_lock_hold();
        t_prio();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("[TB] FAIL watchdog: run did not finish, actual timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule